// File: doc/BRIEF.md
# Bit-Field Extract Insert Unit

A combinational 64-bit execution unit that carries out the bit-field extract and insert operations of a general-purpose integer datapath. It takes one 32-bit instruction word, the source operand and the current destination value. From these it returns the value to be written back to the destination, a write strobe, and a flag that marks encodings it does not accept.

Inside the major opcode group, eight function codes are decoded. Four of them extract a field: a 32-bit form, a 64-bit form, a form that adds 32 to the size, and a form that adds 32 to the starting position. The other four insert a field: a 32-bit form, a 64-bit form, a form that adds 32 to the top bit, and a form that adds 32 to both the top and the bottom bit. Results of the 32-bit forms are sign-extended to 64 bits. An insert whose bit range is empty leaves the destination value untouched. An extract whose field would run off the top of the operand is rejected. Register file access, hazards and mode privilege checks belong to the surrounding pipeline.

Top module: `bfx_unit`

## Requirements
- R1: When instr_i[31:26] is not 6'b011111, wr_en_o and illegal_o are both 0 and rt_o equals rt_i.
- R2: With the major opcode and a function code instr_i[5:0] above 6'b000111, illegal_o is 1, wr_en_o is 0 and rt_o equals rt_i.
- R3: Function 6'b000011 returns rs_i bits [p+s : p], right-justified and zero-filled, with p = instr_i[10:6] and s = instr_i[15:11]. wr_en_o is 1.
- R4: Function 6'b000001 returns rs_i bits [p+s+32 : p], and function 6'b000010 returns rs_i bits [p+32+s : p+32]. Both are zero-filled.
- R5: Function 6'b000000 returns rs_i bits [p+s : p], and bit 31 of that result is copied into bits 63:32.
- R6: An extract whose upper bit index is above 63 (above 31 for function 6'b000000) sets illegal_o to 1 and wr_en_o to 0, and rt_o equals rt_i.
- R7: Let m = instr_i[15:11] and p = instr_i[10:6]. Function 6'b000111 replaces rt_i bits [m:p] with the low bits of rs_i. Function 6'b000101 does the same for bits [m+32:p]. Function 6'b000110 places rs_i shifted by p+32 into bits [m+32:p+32]. All other bits of rt_i are kept.
- R8: Function 6'b000100 inserts into bits [m:p] of the low word, and bit 31 of the merged word is copied into bits 63:32.
- R9: An insert is skipped when p > m (functions 6'b000100, 6'b000111, 6'b000110) or when p > m+32 (function 6'b000101). In that case rt_o equals rt_i, wr_en_o is 1 and illegal_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word: opcode, two register fields, size/top field, position field, function |
| rs_i | input | 64 | Source operand |
| rt_i | input | 64 | Current destination value |
| rt_o | output | 64 | New destination value |
| wr_en_o | output | 1 | Result is to be written back |
| illegal_o | output | 1 | Unaccepted function code or out-of-range extract |

## Verification
Random operands are run through each function code, and the field values are drawn at random as well. This separates the ways each variant biases the position, the size or the top bit by 32. Fixed cases pin down the edges: position 0 with size 31, position equal to the top bit (a one-bit insert), and the largest legal extract next to the smallest illegal one. Skipped inserts use a top bit one below the position, which tests whether the skip comparison includes the bias. Foreign opcodes and unknown function codes show whether the write strobe and the illegal flag keep apart the inputs the unit ignores from the inputs it rejects.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
   localparam int unsigned INSTR_W   = 32;
   localparam int unsigned OPC_W     = 6;
   localparam int unsigned FLD_W     = 5;
   localparam logic [OPC_W-1:0] MAJOR_OPC = 6'b011111;

   typedef enum logic [5:0] {
      FN_EXT_W = 6'b000000,
      FN_EXT_M = 6'b000001,
      FN_EXT_U = 6'b000010,
      FN_EXT_D = 6'b000011,
      FN_INS_W = 6'b000100,
      FN_INS_M = 6'b000101,
      FN_INS_U = 6'b000110,
      FN_INS_D = 6'b000111
   } bfx_fn_e;
endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
   import bfx_pkg::*;
#(
   parameter int unsigned XLEN  = 64,
   parameter int unsigned IDX_W = $clog2(XLEN) + 1
) (
   input  logic [INSTR_W-1:0] instr_i,
   output logic               hit_o,
   output logic               known_o,
   output logic               is_ins_o,
   output logic               narrow_o,
   output logic               fault_o,
   output logic               skip_o,
   output logic [IDX_W-1:0]   lo_o,
   output logic [IDX_W-1:0]   hi_o
);
   localparam int unsigned HALF = XLEN / 2;
   localparam logic [IDX_W-1:0] BIAS = IDX_W'(HALF);

   logic [OPC_W-1:0] opc;
   logic [5:0]       fn;
   logic [IDX_W-1:0] fld_a, fld_b, lim;
   logic             bias_lo, bias_hi;

   assign opc   = instr_i[31:26];
   assign fn    = instr_i[5:0];
   assign fld_a = IDX_W'(instr_i[15:11]);
   assign fld_b = IDX_W'(instr_i[10:6]);
   assign hit_o = (opc == MAJOR_OPC);

   always_comb begin
      known_o  = 1'b1;
      is_ins_o = 1'b0;
      narrow_o = 1'b0;
      bias_lo  = 1'b0;
      bias_hi  = 1'b0;
      case (fn)
         FN_EXT_W: narrow_o = 1'b1;
         FN_EXT_D: ;
         FN_EXT_M: bias_hi  = 1'b1;
         FN_EXT_U: bias_lo  = 1'b1;
         FN_INS_W: begin is_ins_o = 1'b1; narrow_o = 1'b1; end
         FN_INS_D: is_ins_o = 1'b1;
         FN_INS_M: begin is_ins_o = 1'b1; bias_hi = 1'b1; end
         FN_INS_U: begin is_ins_o = 1'b1; bias_hi = 1'b1; bias_lo = 1'b1; end
         default:  known_o = 1'b0;
      endcase
   end

   always_comb begin
      lo_o = fld_b + (bias_lo ? BIAS : '0);
      if (is_ins_o) hi_o = fld_a + (bias_hi ? BIAS : '0);
      else          hi_o = lo_o + fld_a + (bias_hi ? BIAS : '0);
      lim     = narrow_o ? IDX_W'(HALF - 1) : IDX_W'(XLEN - 1);
      fault_o = !is_ins_o && (hi_o > lim);
      skip_o  = is_ins_o && (lo_o > hi_o);
   end
endmodule

// File: rtl/bfx_extract.sv
module bfx_extract #(
   parameter int unsigned XLEN  = 64,
   parameter int unsigned IDX_W = $clog2(XLEN) + 1
) (
   input  logic [XLEN-1:0]  rs_i,
   input  logic [IDX_W-1:0] lo_i,
   input  logic [IDX_W-1:0] hi_i,
   input  logic             narrow_i,
   output logic [XLEN-1:0]  res_o
);
   localparam int unsigned HALF = XLEN / 2;

   logic [XLEN-1:0]  keep, field;
   logic [IDX_W-1:0] span;

   assign span  = hi_i - lo_i;
   assign keep  = ~(({XLEN{1'b1}} << span) << 1);
   assign field = (rs_i >> lo_i) & keep;

   generate
      if (XLEN > HALF) begin : g_sext
         assign res_o = narrow_i ? {{(XLEN-HALF){field[HALF-1]}}, field[HALF-1:0]}
                                 : field;
      end else begin : g_plain
         assign res_o = field;
      end
   endgenerate
endmodule

// File: rtl/bfx_insert.sv
module bfx_insert #(
   parameter int unsigned XLEN  = 64,
   parameter int unsigned IDX_W = $clog2(XLEN) + 1
) (
   input  logic [XLEN-1:0]  rs_i,
   input  logic [XLEN-1:0]  rt_i,
   input  logic [IDX_W-1:0] lo_i,
   input  logic [IDX_W-1:0] hi_i,
   input  logic             narrow_i,
   output logic [XLEN-1:0]  res_o
);
   localparam int unsigned HALF = XLEN / 2;

   logic [XLEN-1:0] mask, merged;

   assign mask   = ({XLEN{1'b1}} << lo_i) & ~(({XLEN{1'b1}} << hi_i) << 1);
   assign merged = rt_i ^ ((rt_i ^ (rs_i << lo_i)) & mask);

   generate
      if (XLEN > HALF) begin : g_sext
         assign res_o = narrow_i ? {{(XLEN-HALF){merged[HALF-1]}}, merged[HALF-1:0]}
                                 : merged;
      end else begin : g_plain
         assign res_o = merged;
      end
   endgenerate
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
   import bfx_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [XLEN-1:0]    rs_i,
   input  logic [XLEN-1:0]    rt_i,
   output logic [XLEN-1:0]    rt_o,
   output logic               wr_en_o,
   output logic               illegal_o
);
   localparam int unsigned IDX_W = $clog2(XLEN) + 1;

   generate
      if (XLEN != 2 * (1 << FLD_W)) begin : g_bad_xlen
         $error("bfx_unit: XLEN must be twice the field range");
      end
   endgenerate

   logic             hit, known, is_ins, narrow, fault, skip;
   logic [IDX_W-1:0] lo, hi;
   logic [XLEN-1:0]  ext_res, ins_res;

   bfx_decode #(.XLEN(XLEN), .IDX_W(IDX_W)) u_dec (
      .instr_i(instr_i), .hit_o(hit), .known_o(known), .is_ins_o(is_ins),
      .narrow_o(narrow), .fault_o(fault), .skip_o(skip), .lo_o(lo), .hi_o(hi)
   );

   bfx_extract #(.XLEN(XLEN), .IDX_W(IDX_W)) u_ext (
      .rs_i(rs_i), .lo_i(lo), .hi_i(hi), .narrow_i(narrow), .res_o(ext_res)
   );

   bfx_insert #(.XLEN(XLEN), .IDX_W(IDX_W)) u_ins (
      .rs_i(rs_i), .rt_i(rt_i), .lo_i(lo), .hi_i(hi), .narrow_i(narrow),
      .res_o(ins_res)
   );

   always_comb begin
      wr_en_o   = hit && known && !fault;
      illegal_o = hit && (!known || fault);
      if (!wr_en_o || skip) rt_o = rt_i;
      else if (is_ins)      rt_o = ins_res;
      else                  rt_o = ext_res;
   end
endmodule

module bfx_unit_chk (
   input logic [31:0] instr_i,
   input logic [63:0] rs_i,
   input logic [63:0] rt_i,
   input logic [63:0] rt_o,
   input logic        wr_en_o,
   input logic        illegal_o
);
   logic [5:0] fn;
   logic [5:0] pos, top;
   assign fn  = instr_i[5:0];
   assign pos = {1'b0, instr_i[10:6]};
   assign top = {1'b0, instr_i[15:11]};

   always_comb begin
      if (!$isunknown({instr_i, rs_i, rt_i, rt_o, wr_en_o, illegal_o})) begin
         // R1
         foreign_quiet_chk: assert (instr_i[31:26] == 6'b011111 || (!wr_en_o && !illegal_o && rt_o == rt_i))
            else $error("foreign opcode produced activity");
         // R2
         excl_flags_chk: assert (!(wr_en_o && illegal_o))
            else $error("write and illegal together");
         // R6
         reject_hold_chk: assert (!illegal_o || rt_o == rt_i)
            else $error("rejected op altered value");
         // R9
         skip_hold_chk: assert (!(instr_i[31:26] == 6'b011111 && (fn == 6'b000100 || fn == 6'b000111 || fn == 6'b000110)
                                 && pos > top) || (rt_o == rt_i && wr_en_o))
            else $error("empty insert changed value");
         // R3
         zero_fill_chk: assert (!(wr_en_o && fn == 6'b000011) || ((rt_o >> (top + 6'd1)) == 64'd0))
            else $error("extract not zero-filled");
         // R7
         low_keep_chk: assert (!(wr_en_o && fn == 6'b000111) || (((rt_o ^ rt_i) & ((64'd1 << pos) - 64'd1)) == 64'd0))
            else $error("insert touched bits below field");
         // R5
         sext_chk: assert (!(wr_en_o && fn == 6'b000000) || rt_o[63:32] == {32{rt_o[31]}})
            else $error("narrow extract not sign-extended");
      end
   end
endmodule

bind bfx_unit bfx_unit_chk u_chk (
   .instr_i(instr_i), .rs_i(rs_i), .rt_i(rt_i),
   .rt_o(rt_o), .wr_en_o(wr_en_o), .illegal_o(illegal_o)
);

// File: tb/bfx_unit_bench.sv
module bfx_unit_bench;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [63:0] rt;
      logic        we;
      logic        ill;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic [31:0] instr;
   logic [63:0] rs, rt;
   logic [63:0] rt_o;
   logic        wr_en, illegal;
   exp_t        sb_q[$];
   int          n_tests = 0;
   int          n_fail  = 0;
   bit          done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bfx_unit u_bfx_unit (
      .instr_i(instr), .rs_i(rs), .rt_i(rt),
      .rt_o(rt_o), .wr_en_o(wr_en), .illegal_o(illegal)
   );

   function automatic void model(input logic [31:0] ins, input logic [63:0] s,
                                 input logic [63:0] d, output exp_t e);
      int lo, hi, lim, fa, fb;
      bit isins, narrow;
      e.rt = d; e.we = 1'b0; e.ill = 1'b0; e.tag = "R1";
      if (ins[31:26] != 6'b011111) return;
      fa = int'(ins[15:11]); fb = int'(ins[10:6]);
      isins = 0; narrow = 0;
      case (ins[5:0])
         6'd0: begin narrow = 1; lo = fb;      hi = fb + fa;      e.tag = "R5"; end
         6'd3: begin             lo = fb;      hi = fb + fa;      e.tag = "R3"; end
         6'd1: begin             lo = fb;      hi = fb + fa + 32; e.tag = "R4"; end
         6'd2: begin             lo = fb + 32; hi = fb + 32 + fa; e.tag = "R4"; end
         6'd4: begin isins = 1; narrow = 1; lo = fb; hi = fa;     e.tag = "R8"; end
         6'd7: begin isins = 1; lo = fb;      hi = fa;            e.tag = "R7"; end
         6'd5: begin isins = 1; lo = fb;      hi = fa + 32;       e.tag = "R7"; end
         6'd6: begin isins = 1; lo = fb + 32; hi = fa + 32;       e.tag = "R7"; end
         default: begin e.ill = 1'b1; e.tag = "R2"; return; end
      endcase
      lim = narrow ? 31 : 63;
      if (!isins) begin
         if (hi > lim) begin e.ill = 1'b1; e.tag = "R6"; return; end
         e.we = 1'b1; e.rt = '0;
         for (int i = 0; i <= hi - lo; i++) e.rt[i] = s[lo + i];
      end else begin
         e.we = 1'b1;
         if (lo > hi) begin e.tag = "R9"; return; end
         for (int i = lo; i <= hi; i++) e.rt[i] = s[i - lo];
      end
      if (narrow) for (int i = 32; i < 64; i++) e.rt[i] = e.rt[31];
   endfunction

   task automatic apply(input logic [31:0] ins, input logic [63:0] s, input logic [63:0] d);
      exp_t e;
      @(posedge clk); #1;
      instr = ins; rs = s; rt = d;
      model(ins, s, d, e);
      sb_q.push_back(e);
   endtask

   function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] fa,
                                      input logic [4:0] fb, input logic [5:0] fn);
      return {opc, 5'd3, 5'd9, fa, fb, fn};
   endfunction

   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         n_tests++;
         if (rt_o !== e.rt || wr_en !== e.we || illegal !== e.ill) begin
            n_fail++;
            $display("FAIL %s instr=%h: rt=%h we=%b ill=%b expected rt=%h we=%b ill=%b",
                     e.tag, instr, rt_o, wr_en, illegal, e.rt, e.we, e.ill);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run hung");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   localparam logic [63:0] PAT_A = 64'hF0E1_D2C3_B4A5_9687;
   localparam logic [63:0] PAT_B = 64'h0123_4567_89AB_CDEF;

   initial begin
      instr = '0; rs = '0; rt = '0;
      // idle state, zero inputs: R1
      apply(32'd0, 64'd0, 64'd0);
      apply(mk(6'b011110, 5'd3, 5'd2, 6'd3), PAT_A, PAT_B);          // R1
      apply(mk(6'b011111, 5'd3, 5'd2, 6'd8), PAT_A, PAT_B);          // R2
      apply(mk(6'b011111, 5'd3, 5'd2, 6'd63), PAT_A, PAT_B);         // R2
      apply(mk(6'b011111, 5'd31, 5'd0, 6'd3), PAT_A, PAT_B);         // R3 lsb=0 size=31
      apply(mk(6'b011111, 5'd31, 5'd31, 6'd3), PAT_A, PAT_B);        // R3 top index 62
      apply(mk(6'b011111, 5'd31, 5'd0, 6'd1), PAT_A, PAT_B);         // R4 full 64
      apply(mk(6'b011111, 5'd0, 5'd31, 6'd1), PAT_A, PAT_B);         // R4 hi=63
      apply(mk(6'b011111, 5'd1, 5'd31, 6'd1), PAT_A, PAT_B);         // R6 hi=64
      apply(mk(6'b011111, 5'd0, 5'd31, 6'd2), PAT_A, PAT_B);         // R4 bit 63
      apply(mk(6'b011111, 5'd1, 5'd31, 6'd2), PAT_A, PAT_B);         // R6
      apply(mk(6'b011111, 5'd31, 5'd0, 6'd0), PAT_A, PAT_B);         // R5 full word
      apply(mk(6'b011111, 5'd0, 5'd31, 6'd0), PAT_A, PAT_B);         // R5 bit 31
      apply(mk(6'b011111, 5'd1, 5'd31, 6'd0), PAT_A, PAT_B);         // R6 narrow
      apply(mk(6'b011111, 5'd9, 5'd9, 6'd7), PAT_A, PAT_B);          // R7 lsb=msb
      apply(mk(6'b011111, 5'd31, 5'd0, 6'd7), PAT_A, PAT_B);         // R7
      apply(mk(6'b011111, 5'd31, 5'd31, 6'd6), PAT_A, PAT_B);        // R7 bit 63
      apply(mk(6'b011111, 5'd31, 5'd0, 6'd5), PAT_A, PAT_B);         // R7 full
      apply(mk(6'b011111, 5'd31, 5'd0, 6'd4), PAT_A, PAT_B);         // R8 full word
      apply(mk(6'b011111, 5'd15, 5'd15, 6'd4), 64'h1, 64'h0);        // R8 lsb=msb
      apply(mk(6'b011111, 5'd4, 5'd5, 6'd7), PAT_A, PAT_B);          // R9
      apply(mk(6'b011111, 5'd4, 5'd5, 6'd6), PAT_A, PAT_B);          // R9
      apply(mk(6'b011111, 5'd4, 5'd5, 6'd4), PAT_A, PAT_B);          // R9 no sext on skip
      apply(mk(6'b011111, 5'd4, 5'd30, 6'd5), PAT_A, PAT_B);         // R7 not skipped
      for (int k = 0; k < 800; k++) begin
         logic [5:0] opc, fn;
         opc = (k % 17 == 0) ? 6'($urandom) : 6'b011111;
         fn  = (k % 13 == 0) ? 6'($urandom) : 6'(k % 8);
         apply(mk(opc, 5'($urandom), 5'($urandom), fn),
               {$urandom, $urandom}, {$urandom, $urandom});
      end
      while (sb_q.size() > 0) @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule